// File: doc/BRIEF.md
# Host Command Message Register Interface

This block is a slave that sits behind a byte transport and gives a host access to a bank of 32-bit registers. The host sends 32-bit words one byte at a time over a valid/ready byte port, most significant byte first. Each message starts with a command word. Its upper half carries an 8-bit module opcode and an operation code, and its lower half carries a 16-bit register index. A write is a command word followed by one data word. A read request asks for one index, or for a run of up to sixteen consecutive indices. The block answers with a response word followed by one data word per index. Command words that carry another module's opcode pass through without effect.

The block can also originate traffic. An internal event posted on the event input is queued as an unsolicited message, and an active-low IRQ tells the host that a message is waiting. Messages on the outbound byte port are never interleaved. When a read reply and an event message are both waiting at a message boundary, the read reply goes first.

Top module: `hostmsg_regif`

## Requirements
- R1: A write is 8 bytes: a command word whose bits 31:16 equal {MOD_OP, 8'h00}, then a data word that is stored at the index in bits 15:0. Bytes arrive most significant first.
- R2: A read request has bits 31:30 and 25:24 equal to the same bits of {MOD_OP, 8'h00}, and bits 23:16 equal to 8'hC0. The reply is the request word with bit 31 cleared, followed by the register data.
- R3: Bits 29:26 of a read request hold the word count minus one. The reply carries that many plus one data words, read from consecutive indices starting at bits 15:0.
- R4: A read of an index at or above NUM_REGS returns zero data, and the response word is still sent.
- R5: A command word whose opcode matches neither own form is ignored and produces no reply. If its bits 23:16 are 8'h00, the following 4 bytes are discarded unparsed.
- R6: While an event message is queued, irqN is low. The message is the word {MOD_OP, 8'h00, event index} followed by the event data word.
- R7: irqN returns high in the cycle after the last byte of the last queued message is taken. The queue holds EVQ_DEPTH messages, and an event posted while the queue is full is dropped.
- R8: Outbound messages are never interleaved. When a read reply and a queued event both wait at a message boundary, the read reply is sent first. outData holds while outValid is high and outReady is low.
- R9: inReady is low from the end of a read request until the last byte of its reply has been taken.
- R10: After reset all registers read zero, irqN is high, outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Host byte is valid |
| inData | input | 8 | Host byte |
| inReady | output | 1 | Block accepts a host byte |
| outValid | output | 1 | Outbound byte is valid |
| outData | output | 8 | Outbound byte |
| outReady | input | 1 | Host takes the outbound byte |
| evtValid | input | 1 | Post an internal event (one-cycle pulse) |
| evtIndex | input | 16 | Event type index |
| evtData | input | 32 | Event detail word |
| irqN | output | 1 | Low while an event message is queued |

## Verification
The assertions rely on the host following the byte handshake. The host keeps inData steady until inReady accepts it, and it does not count on outData changing while it withholds outReady. The assertions also require MOD_OP bits 5:2 to be zero, so that the count field cannot alias the opcode. The bench drives every byte through tasks that wait for the handshake at the falling edge, and it posts each event as a single-cycle pulse. It also uses the default opcode, which meets that constraint. A foreign write in the stimulus carries a data word that looks like a valid write command, so any failure to discard it shows up as a parsing error.

// File: rtl/hostmsg_pkg.sv
package hostmsg_pkg;

  typedef enum logic [1:0] {RX_CMD, RX_DATA, RX_SKIP, RX_WAIT} rxState_t;
  typedef enum logic [1:0] {TX_IDLE, TX_REPLY, TX_UNSOL} txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic latchCmd;
    logic regWrite;
    logic loadReply;
    logic loadData;
    logic loadEvtWord;
    logic loadEvtData;
    logic shiftOut;
    logic evtPush;
    logic evtPop;
  } dpStrobe_t;

  function automatic logic isOwnWrite(input logic [15:0] op, input logic [7:0] mod);
    return op == {mod, 8'h00};
  endfunction

  // bits 13:10 of op (word bits 29:26) carry the count and are masked
  function automatic logic isOwnRead(input logic [15:0] op, input logic [7:0] mod);
    return ({op[15:14], op[9:8]} == {mod[7:6], mod[1:0]}) && (op[7:0] == 8'hC0);
  endfunction

  function automatic logic isForeignWrite(input logic [15:0] op, input logic [7:0] mod);
    return (op[7:0] == 8'h00) && !isOwnWrite(op, mod);
  endfunction

endpackage

// File: rtl/hostmsg_dp.sv
module hostmsg_dp
  import hostmsg_pkg::*;
#(
  parameter logic [7:0] MOD_OP    = 8'h82,
  parameter int         NUM_REGS  = 16,
  parameter int         EVQ_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strobe,
  input  logic [7:0]  inData,
  input  logic [15:0] evtIndex,
  input  logic [31:0] evtData,
  output logic [15:0] rxOpNow,
  output logic [3:0]  countField,
  output logic [7:0]  outData,
  output logic        evqEmpty,
  output logic        evqFull
);

  localparam int REG_AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int PTR_W  = (EVQ_DEPTH > 1) ? $clog2(EVQ_DEPTH) : 1;
  localparam int CNT_W  = $clog2(EVQ_DEPTH + 1);

  logic [23:0] rxShift;
  logic [31:0] rxWordNow;
  logic [30:0] cmdReg;
  logic [15:0] readIdx;
  logic [31:0] txShift;
  logic [31:0] bank [NUM_REGS];

  logic [15:0] evqIdx  [EVQ_DEPTH];
  logic [31:0] evqData [EVQ_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] evqCount;

  function automatic logic inRange(input logic [15:0] idx);
    return 32'(idx) < NUM_REGS;
  endfunction

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(EVQ_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign rxWordNow  = {rxShift, inData};
  assign rxOpNow    = rxWordNow[31:16];
  assign countField = cmdReg[29:26];
  assign outData    = txShift[31:24];
  assign evqEmpty   = (evqCount == '0);
  assign evqFull    = (evqCount == CNT_W'(EVQ_DEPTH));

  logic [31:0] rdValue;
  assign rdValue = inRange(readIdx) ? bank[readIdx[REG_AW-1:0]] : 32'h0;

  // receive shifter and command latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      cmdReg  <= '0;
    end else begin
      if (strobe.shiftIn)  rxShift <= {rxShift[15:0], inData};
      if (strobe.latchCmd) cmdReg  <= rxWordNow[30:0];
    end
  end

  // register bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else if (strobe.regWrite && inRange(cmdReg[15:0])) begin
      bank[cmdReg[REG_AW-1:0]] <= rxWordNow;
    end
  end

  // transmit shifter and read pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      readIdx <= '0;
    end else begin
      if (strobe.loadReply) begin
        txShift <= {1'b0, cmdReg};
        readIdx <= cmdReg[15:0];
      end else if (strobe.loadData) begin
        txShift <= rdValue;
        readIdx <= readIdx + 16'd1;
      end else if (strobe.loadEvtWord) begin
        txShift <= {MOD_OP, 8'h00, evqIdx[rdPtr]};
      end else if (strobe.loadEvtData) begin
        txShift <= evqData[rdPtr];
      end else if (strobe.shiftOut) begin
        txShift <= {txShift[23:0], 8'h00};
      end
    end
  end

  // event queue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      evqCount <= '0;
      for (int i = 0; i < EVQ_DEPTH; i++) begin
        evqIdx[i]  <= '0;
        evqData[i] <= '0;
      end
    end else begin
      if (strobe.evtPush) begin
        evqIdx[wrPtr]  <= evtIndex;
        evqData[wrPtr] <= evtData;
        wrPtr          <= nextPtr(wrPtr);
      end
      if (strobe.evtPop) rdPtr <= nextPtr(rdPtr);
      case ({strobe.evtPush, strobe.evtPop})
        2'b10:   evqCount <= evqCount + CNT_W'(1);
        2'b01:   evqCount <= evqCount - CNT_W'(1);
        default: evqCount <= evqCount;
      endcase
    end
  end

  // R7
  evq_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    evqCount <= CNT_W'(EVQ_DEPTH));

endmodule

// File: rtl/hostmsg_ctrl.sv
module hostmsg_ctrl
  import hostmsg_pkg::*;
#(
  parameter logic [7:0] MOD_OP = 8'h82
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        evtValid,
  input  logic [15:0] rxOpNow,
  input  logic [3:0]  countField,
  input  logic        evqEmpty,
  input  logic        evqFull,
  output logic        inReady,
  output logic        outValid,
  output dpStrobe_t   strobe
);

  rxState_t   rxState;
  txState_t   txState;
  logic [1:0] rxCnt;
  logic [1:0] txCnt;
  logic [4:0] wordsLeft;

  logic inFire, outFire, lastByte, wordEnd;
  logic startReply, startUnsol, replyFinish;

  assign inReady     = (rxState != RX_WAIT);
  assign outValid    = (txState != TX_IDLE);
  assign inFire      = inValid && inReady;
  assign outFire     = outValid && outReady;
  assign lastByte    = (txCnt == 2'd3);
  assign wordEnd     = outFire && lastByte;
  assign startReply  = (txState == TX_IDLE) && (rxState == RX_WAIT);
  assign startUnsol  = (txState == TX_IDLE) && !startReply && !evqEmpty;
  assign replyFinish = wordEnd && (txState == TX_REPLY) && (wordsLeft == 5'd0);

  always_comb begin
    strobe             = '0;
    strobe.shiftIn     = inFire;
    strobe.latchCmd    = inFire && (rxState == RX_CMD)  && (rxCnt == 2'd3);
    strobe.regWrite    = inFire && (rxState == RX_DATA) && (rxCnt == 2'd3);
    strobe.loadReply   = startReply;
    strobe.loadEvtWord = startUnsol;
    strobe.loadData    = wordEnd && (txState == TX_REPLY) && (wordsLeft != 5'd0);
    strobe.loadEvtData = wordEnd && (txState == TX_UNSOL) && (wordsLeft != 5'd0);
    strobe.evtPop      = wordEnd && (txState == TX_UNSOL) && (wordsLeft == 5'd0);
    strobe.shiftOut    = outFire && !lastByte;
    strobe.evtPush     = evtValid && !evqFull;
  end

  // receive sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_CMD;
      rxCnt   <= '0;
    end else begin
      case (rxState)
        RX_CMD: if (inFire) begin
          rxCnt <= rxCnt + 2'd1;
          if (rxCnt == 2'd3) begin
            if (isOwnWrite(rxOpNow, MOD_OP))          rxState <= RX_DATA;
            else if (isOwnRead(rxOpNow, MOD_OP))      rxState <= RX_WAIT;
            else if (isForeignWrite(rxOpNow, MOD_OP)) rxState <= RX_SKIP;
          end
        end
        RX_DATA, RX_SKIP: if (inFire) begin
          rxCnt <= rxCnt + 2'd1;
          if (rxCnt == 2'd3) rxState <= RX_CMD;
        end
        RX_WAIT: if (replyFinish) rxState <= RX_CMD;
        default: rxState <= RX_CMD;
      endcase
    end
  end

  // transmit sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState   <= TX_IDLE;
      txCnt     <= '0;
      wordsLeft <= '0;
    end else begin
      case (txState)
        TX_IDLE: begin
          txCnt <= '0;
          if (startReply) begin
            txState   <= TX_REPLY;
            wordsLeft <= {1'b0, countField} + 5'd1;
          end else if (startUnsol) begin
            txState   <= TX_UNSOL;
            wordsLeft <= 5'd1;
          end
        end
        TX_REPLY, TX_UNSOL: if (outFire) begin
          txCnt <= txCnt + 2'd1;
          if (lastByte) begin
            if (wordsLeft != 5'd0) wordsLeft <= wordsLeft - 5'd1;
            else                   txState   <= TX_IDLE;
          end
        end
        default: txState <= TX_IDLE;
      endcase
    end
  end

  // R9
  reply_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_REPLY) |-> (rxState == RX_WAIT));

  // R6
  unsol_has_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_UNSOL) |-> !evqEmpty);

  // R3
  burst_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordsLeft <= 5'd16);

endmodule

// File: rtl/hostmsg_regif.sv
module hostmsg_regif
  import hostmsg_pkg::*;
#(
  parameter logic [7:0] MOD_OP    = 8'h82,
  parameter int         NUM_REGS  = 16,
  parameter int         EVQ_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  inData,
  output logic        inReady,
  output logic        outValid,
  output logic [7:0]  outData,
  input  logic        outReady,
  input  logic        evtValid,
  input  logic [15:0] evtIndex,
  input  logic [31:0] evtData,
  output logic        irqN
);

  dpStrobe_t   strobe;
  logic [15:0] rxOpNow;
  logic [3:0]  countField;
  logic        evqEmpty, evqFull;

  hostmsg_ctrl #(.MOD_OP(MOD_OP)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .outReady   (outReady),
    .evtValid   (evtValid),
    .rxOpNow    (rxOpNow),
    .countField (countField),
    .evqEmpty   (evqEmpty),
    .evqFull    (evqFull),
    .inReady    (inReady),
    .outValid   (outValid),
    .strobe     (strobe)
  );

  hostmsg_dp #(.MOD_OP(MOD_OP), .NUM_REGS(NUM_REGS), .EVQ_DEPTH(EVQ_DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inData     (inData),
    .evtIndex   (evtIndex),
    .evtData    (evtData),
    .rxOpNow    (rxOpNow),
    .countField (countField),
    .outData    (outData),
    .evqEmpty   (evqEmpty),
    .evqFull    (evqFull)
  );

  assign irqN = evqEmpty;

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

endmodule

// File: tb/tb_hostmsg_regif.sv
`timescale 1ns/1ps
module tb_hostmsg_regif;

  localparam logic [7:0] MOD = 8'h82;
  localparam int NREG = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inReady;
  logic        outValid;
  logic [7:0]  outData;
  logic        outReady = 1'b0;
  logic        evtValid = 1'b0;
  logic [15:0] evtIndex = '0;
  logic [31:0] evtData = '0;
  logic        irqN;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [NREG];

  always #2.5 clk = ~clk;

  hostmsg_regif #(.MOD_OP(MOD), .NUM_REGS(NREG), .EVQ_DEPTH(2)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .evtValid(evtValid), .evtIndex(evtIndex), .evtData(evtData), .irqN(irqN)
  );

  // {index, data} pairs for write then read-back
  localparam logic [47:0] VEC [8] = '{
    {16'h0000, 32'h1234_5678}, {16'h000F, 32'hFFFF_0001},
    {16'h0007, 32'hA5A5_5A5A}, {16'h0003, 32'h0000_0001},
    {16'h0009, 32'h8000_0000}, {16'h0001, 32'hDEAD_BEEF},
    {16'h000C, 32'h0BAD_F00D}, {16'h0007, 32'h1357_9BDF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1;
    inData  = b;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic sendWord(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) sendByte(w[i*8 +: 8]);
  endtask

  task automatic recvByte(output logic [7:0] b);
    @(negedge clk);
    outReady = 1'b1;
    while (!outValid) @(negedge clk);
    b = outData;
    @(posedge clk);
    #1 outReady = 1'b0;
  endtask

  task automatic recvWord(output logic [31:0] w);
    logic [7:0] b;
    for (int i = 3; i >= 0; i--) begin
      recvByte(b);
      w[i*8 +: 8] = b;
    end
  endtask

  function automatic logic [31:0] expRd(input logic [15:0] idx);
    return (32'(idx) < NREG) ? model[idx[3:0]] : 32'h0;
  endfunction

  task automatic doWrite(input logic [15:0] idx, input logic [31:0] d);
    sendWord({MOD, 8'h00, idx});
    sendWord(d);
    if (32'(idx) < NREG) model[idx[3:0]] = d;
  endtask

  task automatic recvReply(input string req, input logic [15:0] idx, input logic [3:0] n);
    logic [31:0] w;
    logic [31:0] rq;
    rq = {MOD, 8'hC0, idx} | (32'(n) << 26);
    recvWord(w);
    check(req, w, rq & 32'h7FFF_FFFF);
    for (int k = 0; k <= int'(n); k++) begin
      recvWord(w);
      check(req, w, expRd(idx + 16'(k)));
    end
  endtask

  task automatic doRead(input string req, input logic [15:0] idx, input logic [3:0] n);
    sendWord({MOD, 8'hC0, idx} | (32'(n) << 26));
    recvReply(req, idx, n);
  endtask

  task automatic postEvent(input logic [15:0] idx, input logic [31:0] d);
    @(negedge clk);
    evtValid = 1'b1; evtIndex = idx; evtData = d;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic recvUnsol(input string req, input logic [15:0] idx, input logic [31:0] d);
    logic [31:0] w;
    recvWord(w);
    check(req, w, {MOD, 8'h00, idx});
    recvWord(w);
    check(req, w, d);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] w;
    bit quiet;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R10 reset state
    @(negedge clk);
    check("R10 irqN", 32'(irqN), 32'd1);
    check("R10 outValid", 32'(outValid), 32'd0);
    check("R10 inReady", 32'(inReady), 32'd1);
    doRead("R10 reg zero", 16'h0003, 4'd0);

    // R1 R2 vector table: write, then single read-back
    for (int v = 0; v < 8; v++) begin
      doWrite(VEC[v][47:32], VEC[v][31:0]);
      doRead("R1 R2 readback", VEC[v][47:32], 4'd0);
    end

    // R3 R4 sixteen-word burst crossing the end of the bank
    doRead("R3 R4 burst", 16'h0008, 4'd15);
    // R3 short burst
    doRead("R3 burst3", 16'h0000, 4'd2);
    // R4 far out of range
    doRead("R4 oob", 16'h1234, 4'd0);

    // R5 foreign write whose data looks like an own write command
    sendWord({8'h90, 8'h00, 16'h0002});
    sendWord({MOD, 8'h00, 16'h0002});
    doRead("R5 foreign write", 16'h0002, 4'd0);

    // R5 foreign read gives no reply
    sendWord({8'h90, 8'hC0, 16'h0001});
    quiet = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (outValid) quiet = 1'b0;
    end
    check("R5 no reply", 32'(quiet), 32'd1);

    // R9 inReady low while a reply is outstanding
    sendWord({MOD, 8'hC0, 16'h0004} | (32'd3 << 26));
    @(negedge clk);
    check("R9 inReady low", 32'(inReady), 32'd0);
    recvReply("R9 reply", 16'h0004, 4'd3);
    @(negedge clk);
    check("R9 inReady back", 32'(inReady), 32'd1);

    // R6 R7 single unsolicited message
    postEvent(16'h0042, 32'hCAFE_F00D);
    check("R6 irq low", 32'(irqN), 32'd0);
    recvUnsol("R6 message", 16'h0042, 32'hCAFE_F00D);
    @(negedge clk);
    check("R7 irq release", 32'(irqN), 32'd1);

    // R7 queue depth: third event dropped
    postEvent(16'h0001, 32'h1111_1111);
    postEvent(16'h0002, 32'h2222_2222);
    postEvent(16'h0003, 32'h3333_3333);
    recvUnsol("R7 first", 16'h0001, 32'h1111_1111);
    @(negedge clk);
    check("R7 irq held", 32'(irqN), 32'd0);
    recvUnsol("R7 second", 16'h0002, 32'h2222_2222);
    @(negedge clk);
    check("R7 irq after drain", 32'(irqN), 32'd1);
    quiet = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (outValid) quiet = 1'b0;
    end
    check("R7 dropped", 32'(quiet), 32'd1);

    // R8 ordering: unsol A in flight, reply beats queued unsol B
    postEvent(16'h00A0, 32'hAAAA_0000);
    postEvent(16'h00B0, 32'hBBBB_0000);
    sendWord({MOD, 8'hC0, 16'h0001});
    recvUnsol("R8 first unsol", 16'h00A0, 32'hAAAA_0000);
    recvReply("R8 reply second", 16'h0001, 4'd0);
    recvUnsol("R8 last unsol", 16'h00B0, 32'hBBBB_0000);
    @(negedge clk);
    check("R8 irq end", 32'(irqN), 32'd1);

    // R8 hold: outData stable while host stalls
    postEvent(16'h0055, 32'h9876_5432);
    @(negedge clk);
    w[7:0] = outData;
    repeat (5) @(negedge clk);
    check("R8 hold", 32'(outData), 32'(w[7:0]));
    recvUnsol("R8 after stall", 16'h0055, 32'h9876_5432);

    finishRun();
  end

endmodule